// File: doc/BRIEF.md
# MDIO Single-Command Management Master

This block lets software run one clause-22 management transaction against an external PHY for each command it issues. Software loads a 16-bit value into the low half of the data register when it wants a write. It then writes the command register with the go bit, one opcode bit, a PHY address and a register address. The block latches the command and raises its busy indication. It then shifts a complete 64-bit management frame onto the serial pins, with the management clock derived from the system clock. When the frame ends it clears busy.

A read returns the 16-bit value from the PHY in the upper half of the data register. The status register records whether the PHY answered. If the PHY leaves the line high during the second turnaround bit, the read is flagged invalid. The serial data line is split into an output, an output enable and an input, so the pad ring builds the bidirectional pin. The line is assumed to have a pull-up.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After synchronous reset, the command, data and status registers read 0, `mdc` is low and `mdio_oe` is low.
- R2: A write command sends these bits MSB first, one bit per MDC period, 64 bits in all: 32 ones, start `01`, opcode `01`, the 5-bit PHY address (command bits 12:8), the 5-bit register address (command bits 4:0), turnaround `10`, then bits 15:0 of the data register. `mdio_oe` is high for all 64 bits.
- R3: A read command sends the same preamble and start, then opcode `10`, the PHY address and the register address. From the first turnaround bit to the end of the frame (the last 18 bits), `mdio_oe` is low.
- R4: Command register bit 20 reads 1 from the edge that accepts a command. It reads 0 from the edge exactly 128×`HALF_DIV` clock cycles later, when the frame ends.
- R5: When a read ends, the 16 bits sampled on the MDC rising edges of frame bits 48..63 (MSB first) appear in data bits 31:16. Bits 15:0 keep the value software wrote.
- R6: Status bit 0 is set at the end of a read if the line was high at the rising edge of the second turnaround bit. It is cleared at the end of a read in which the line was low there. A write leaves it unchanged.
- R7: MDC is high for `HALF_DIV` cycles and low for `HALF_DIV` cycles. It starts low and stays low while idle. `mdio_out` and `mdio_oe` never change while MDC is high.
- R8: A command-register write while busy is ignored: no frame starts, and the command readback and the frame in progress are unchanged.
- R9: A command-register write that does not have bit 20 set together with exactly one of bit 17 (read) or bit 16 (write) starts nothing and leaves the command readback unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wsel | input | 2 | Write select: 0 command, 1 data, 2 status |
| reg_wdata | input | 32 | Register write value |
| reg_rsel | input | 2 | Read select, same encoding as the write select |
| reg_rdata | output | 32 | Selected register contents (combinational) |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Serial data driven by the master |
| mdio_oe | output | 1 | Output enable for the data pin |
| mdio_in | input | 1 | Serial data seen on the pin |

## Verification
Accepting a command at edge E0 gives MDC rising edges at E0+(2k+1)·`HALF_DIV` for frame bit k. Busy, the returned data and the status flag all change together at E0+128·`HALF_DIV`. The bench counts clock edges from the accepting edge. It reads busy at the falling clock edge one cycle before that instant and again at the instant, expecting 1 and then 0. Data and status are read only after that. The scoreboard samples the pin at each MDC rise and compares the 64th bit, due at E0+127·`HALF_DIV`, against the frame queued when the command was issued. The PHY model drives its bits only after MDC falls.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    typedef enum logic [1:0] {
        SEL_CMD  = 2'd0,
        SEL_DATA = 2'd1,
        SEL_STAT = 2'd2
    } reg_sel_e;

    typedef enum logic {
        OP_WRITE = 1'b0,
        OP_READ  = 1'b1
    } mdio_op_e;

    localparam int FIELD_W    = 5;
    localparam int VAL_W      = 16;
    localparam int WORD_W     = 32;
    localparam int PRE_BITS   = 32;
    localparam int FRAME_BITS = 64;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int BIT_GO     = 20;
    localparam int BIT_RD     = 17;
    localparam int BIT_WR     = 16;
    localparam int PHY_LSB    = 8;
    localparam int REG_LSB    = 0;
    localparam int TA_FIRST   = 46;
    localparam int TA_SECOND  = 47;
    localparam int DATA_FIRST = 48;

    localparam logic [WORD_W-1:0] CMD_KEEP =
        (WORD_W'(1) << BIT_RD) | (WORD_W'(1) << BIT_WR) |
        (WORD_W'((1 << FIELD_W) - 1) << PHY_LSB) |
        (WORD_W'((1 << FIELD_W) - 1) << REG_LSB);

    typedef struct packed {
        mdio_op_e           op;
        logic [FIELD_W-1:0] phy;
        logic [FIELD_W-1:0] regad;
        logic [VAL_W-1:0]   wval;
    } mdio_req_t;

    function automatic logic cmd_is_valid(logic [WORD_W-1:0] w);
        return w[BIT_GO] && (w[BIT_RD] ^ w[BIT_WR]);
    endfunction

    function automatic mdio_req_t decode_cmd(logic [WORD_W-1:0] w, logic [VAL_W-1:0] v);
        mdio_req_t r;
        r.op    = w[BIT_RD] ? OP_READ : OP_WRITE;
        r.phy   = w[PHY_LSB +: FIELD_W];
        r.regad = w[REG_LSB +: FIELD_W];
        r.wval  = v;
        return r;
    endfunction

    function automatic logic [FRAME_BITS-1:0] build_frame(mdio_req_t r);
        logic [1:0]       opc;
        logic [1:0]       ta;
        logic [VAL_W-1:0] body;
        opc  = (r.op == OP_READ) ? 2'b10 : 2'b01;
        ta   = (r.op == OP_READ) ? 2'b11 : 2'b10;
        body = (r.op == OP_READ) ? {VAL_W{1'b1}} : r.wval;
        return {{PRE_BITS{1'b1}}, 2'b01, opc, r.phy, r.regad, ta, body};
    endfunction

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
    parameter int HALF_DIV = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic mdc,
    output logic rise,
    output logic fall
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_q;
    logic          mdc_q;
    logic          wrap;

    assign wrap = run && (cnt_q == LAST);
    assign rise = wrap && !mdc_q;
    assign fall = wrap && mdc_q;
    assign mdc  = mdc_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assert_edges_alternate_R7: assert property (@(posedge clk) disable iff (rst)
        rise |=> mdc_q && !rise);

endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
    import mdio_mgmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  mdio_req_t        req,
    input  logic             rise,
    input  logic             fall,
    input  logic             mdio_in,
    output logic             mdio_out,
    output logic             mdio_oe,
    output logic             done,
    output logic [VAL_W-1:0] rd_val,
    output logic             ta_bad
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

    logic                  active_q;
    mdio_op_e              op_q;
    logic [IDX_W-1:0]      idx_q;
    logic [FRAME_BITS-1:0] shift_q;
    logic [VAL_W-1:0]      rd_q;
    logic                  ta_bad_q;
    logic                  in_read_tail;

    assign in_read_tail = (op_q == OP_READ) && (idx_q >= IDX_W'(TA_FIRST));
    assign mdio_out     = !active_q || shift_q[FRAME_BITS-1];
    assign mdio_oe      = active_q && !in_read_tail;
    assign done         = active_q && fall && (idx_q == LAST_IDX);
    assign rd_val       = rd_q;
    assign ta_bad       = ta_bad_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            op_q     <= OP_WRITE;
            idx_q    <= '0;
            shift_q  <= '0;
            rd_q     <= '0;
            ta_bad_q <= 1'b0;
        end else if (start) begin
            active_q <= 1'b1;
            op_q     <= req.op;
            idx_q    <= '0;
            shift_q  <= build_frame(req);
            rd_q     <= '0;
            ta_bad_q <= 1'b0;
        end else if (active_q) begin
            if (fall) begin
                if (idx_q == LAST_IDX) begin
                    active_q <= 1'b0;
                end else begin
                    idx_q   <= idx_q + IDX_W'(1);
                    shift_q <= {shift_q[FRAME_BITS-2:0], 1'b0};
                end
            end
            if (rise && (op_q == OP_READ)) begin
                if (idx_q == IDX_W'(TA_SECOND))
                    ta_bad_q <= mdio_in;
                if (idx_q >= IDX_W'(DATA_FIRST))
                    rd_q <= {rd_q[VAL_W-2:0], mdio_in};
            end
        end
    end

    assert_single_done_R4: assert property (@(posedge clk) disable iff (rst)
        done |=> !done && !mdio_oe);

    assert_no_restart_R8: assert property (@(posedge clk) disable iff (rst)
        active_q && !done |=> active_q);

endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
    import mdio_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [1:0]        rd_sel,
    input  logic              done,
    input  logic [VAL_W-1:0]  rd_val,
    input  logic              ta_bad,
    output logic [WORD_W-1:0] rd_data,
    output logic              busy,
    output logic              start,
    output mdio_req_t         req
);
    logic [WORD_W-1:0] cmd_q;
    logic [VAL_W-1:0]  lo_q;
    logic [VAL_W-1:0]  hi_q;
    logic              busy_q;
    logic              bad_q;
    logic              cmd_hit;
    logic              data_hit;

    assign cmd_hit  = wr_en && (reg_sel_e'(wr_sel) == SEL_CMD);
    assign data_hit = wr_en && (reg_sel_e'(wr_sel) == SEL_DATA);
    assign start    = cmd_hit && !busy_q && cmd_is_valid(wr_data);
    assign req      = decode_cmd(wr_data, lo_q);
    assign busy     = busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            lo_q   <= '0;
            hi_q   <= '0;
            busy_q <= 1'b0;
            bad_q  <= 1'b0;
        end else begin
            if (start) begin
                cmd_q  <= wr_data & CMD_KEEP;
                busy_q <= 1'b1;
            end else if (done) begin
                busy_q <= 1'b0;
                if (cmd_q[BIT_RD]) begin
                    hi_q  <= rd_val;
                    bad_q <= ta_bad;
                end
            end
            if (data_hit)
                lo_q <= wr_data[VAL_W-1:0];
        end
    end

    always_comb begin
        rd_data = '0;
        case (reg_sel_e'(rd_sel))
            SEL_CMD:  rd_data = cmd_q | (WORD_W'(busy_q) << BIT_GO);
            SEL_DATA: rd_data = {hi_q, lo_q};
            SEL_STAT: rd_data = {{(WORD_W-1){1'b0}}, bad_q};
            default:  rd_data = '0;
        endcase
    end

    assert_busy_drop_R4: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy_q);

    assert_ignore_busy_R8: assert property (@(posedge clk) disable iff (rst)
        busy_q && cmd_hit |=> $stable(cmd_q));

    assert_write_keeps_status_R6: assert property (@(posedge clk) disable iff (rst)
        done && !cmd_q[BIT_RD] |=> $stable(bad_q) && $stable(hi_q));

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_mgmt_pkg::*;
#(
    parameter int HALF_DIV = 50
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [1:0]  reg_wsel,
    input  logic [31:0] reg_wdata,
    input  logic [1:0]  reg_rsel,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_out,
    output logic        mdio_oe,
    input  logic        mdio_in
);
    logic             busy;
    logic             start;
    logic             done;
    logic             rise;
    logic             fall;
    logic             ta_bad;
    logic [VAL_W-1:0] rd_val;
    mdio_req_t        req;

    mdio_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr),
        .wr_sel  (reg_wsel),
        .wr_data (reg_wdata),
        .rd_sel  (reg_rsel),
        .done    (done),
        .rd_val  (rd_val),
        .ta_bad  (ta_bad),
        .rd_data (reg_rdata),
        .busy    (busy),
        .start   (start),
        .req     (req)
    );

    mdio_clk_div #(.HALF_DIV(HALF_DIV)) u_div (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .mdc  (mdc),
        .rise (rise),
        .fall (fall)
    );

    mdio_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .req      (req),
        .rise     (rise),
        .fall     (fall),
        .mdio_in  (mdio_in),
        .mdio_out (mdio_out),
        .mdio_oe  (mdio_oe),
        .done     (done),
        .rd_val   (rd_val),
        .ta_bad   (ta_bad)
    );

    assert_idle_pins_R7: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdc && !mdio_oe);

    assert_hold_while_high_R7: assert property (@(posedge clk) disable iff (rst)
        mdc && $past(mdc) |-> $stable(mdio_out) && $stable(mdio_oe));

endmodule

// File: tb/mdio_mgmt_ctrl_bench.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl_bench;
    localparam int HALF = 50;
    localparam int FRAME_CYC = 128 * HALF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_wsel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [1:0]  reg_rsel = 2'd0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_out, mdio_oe, mdio_in;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int c0 = 0;

    // PHY model state
    logic        phy_en = 1'b0, phy_bit = 1'b1;
    logic        cur_read = 1'b0, cur_respond = 1'b0;
    logic [15:0] cur_rval = '0;

    // scoreboard
    logic [63:0] exp_q[$];
    logic [63:0] msk_q[$];
    logic [63:0] cap_bits = '0, cap_oe = '0;
    int          bitcnt = 0;
    int          timing_viol = 0;
    int          run_len = 0;
    logic        mdc_prev = 1'b0, out_prev = 1'b1, oe_prev = 1'b0;

    assign mdio_in = phy_en ? phy_bit : 1'b1;

    mdio_mgmt_ctrl #(.HALF_DIV(HALF)) u_mdio_mgmt_ctrl (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wsel(reg_wsel),
        .reg_wdata(reg_wdata), .reg_rsel(reg_rsel), .reg_rdata(reg_rdata),
        .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary_and_end;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic wr_reg(input logic [1:0] sel, input logic [31:0] val);
        @(negedge clk);
        reg_wr = 1'b1; reg_wsel = sel; reg_wdata = val;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] sel, output logic [31:0] val);
        reg_rsel = sel;
        #1;
        val = reg_rdata;
    endtask

    function automatic logic [31:0] cmd_word(input bit rd, input logic [4:0] phy, input logic [4:0] ra);
        return (32'd1 << 20) | (rd ? (32'd1 << 17) : (32'd1 << 16)) | {19'd0, phy, 3'd0, ra};
    endfunction

    // driver: queue the expected frame, then issue the command
    task automatic launch(input bit rd, input logic [4:0] phy, input logic [4:0] ra,
                          input logic [15:0] wval, input bit respond, input logic [15:0] rval);
        logic [63:0] f;
        if (rd)
            f = {32'hFFFF_FFFF, 2'b01, 2'b10, phy, ra, 1'b1,
                 respond ? 1'b0 : 1'b1, respond ? rval : 16'hFFFF};
        else
            f = {32'hFFFF_FFFF, 2'b01, 2'b01, phy, ra, 2'b10, wval};
        exp_q.push_back(f);
        msk_q.push_back(rd ? {{46{1'b1}}, 18'd0} : {64{1'b1}});
        cur_read = rd; cur_respond = respond; cur_rval = rval;
        wr_reg(2'd0, cmd_word(rd, phy, ra));
        c0 = cyc;
    endtask

    task automatic wait_done(input string tag);
        logic [31:0] v;
        while (cyc < c0 + FRAME_CYC - 1) @(negedge clk);
        rd_reg(2'd0, v);
        chk(v[20] == 1'b1, {tag, " busy one cycle before end"}, 64'(v[20]), 64'd1);
        @(negedge clk);
        rd_reg(2'd0, v);
        chk(v[20] == 1'b0, {tag, " busy clear at end"}, 64'(v[20]), 64'd0);
    endtask

    // monitor + PHY model, evaluated away from the active edge
    always @(negedge clk) begin
        if (rst) begin
            mdc_prev = 1'b0; run_len = 0;
        end else begin
            if (mdc && mdc_prev && (mdio_out != out_prev || mdio_oe != oe_prev))
                timing_viol++;
            if (mdc != mdc_prev) begin
                if (!mdc && run_len != HALF) timing_viol++;
                if (mdc && bitcnt > 0 && run_len != HALF) timing_viol++;
                run_len = 1;
            end else begin
                run_len++;
            end
            if (mdc && !mdc_prev) begin
                cap_bits = {cap_bits[62:0], mdio_oe ? mdio_out : mdio_in};
                cap_oe   = {cap_oe[62:0], mdio_oe};
                bitcnt++;
                if (bitcnt == 64) begin
                    bitcnt = 0;
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R8 unexpected frame", cap_bits, 64'd0);
                    end else begin
                        logic [63:0] ef, em;
                        ef = exp_q.pop_front();
                        em = msk_q.pop_front();
                        chk(cap_bits == ef, em[0] ? "R2 write frame bits" : "R3 read frame bits", cap_bits, ef);
                        chk(cap_oe == em, em[0] ? "R2 write drive enable" : "R3 read release", cap_oe, em);
                    end
                end
            end
            if (!mdc && mdc_prev) begin
                if (cur_read && cur_respond && bitcnt >= 47 && bitcnt <= 63) begin
                    phy_en  = 1'b1;
                    phy_bit = (bitcnt == 47) ? 1'b0 : cur_rval[63 - bitcnt];
                end else begin
                    phy_en = 1'b0;
                end
            end
            mdc_prev = mdc; out_prev = mdio_out; oe_prev = mdio_oe;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary_and_end();
    end

    initial begin
        logic [31:0] v;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        rd_reg(2'd0, v); chk(v == 0, "R1 command reset", 64'(v), 64'd0);
        rd_reg(2'd1, v); chk(v == 0, "R1 data reset", 64'(v), 64'd0);
        rd_reg(2'd2, v); chk(v == 0, "R1 status reset", 64'(v), 64'd0);
        chk(!mdc && !mdio_oe, "R1 pins idle", {62'd0, mdc, mdio_oe}, 64'd0);

        // R2 write transaction, R4 busy timing, R6 write keeps status
        wr_reg(2'd1, 32'h0000_A5C3);
        launch(1'b0, 5'd5, 5'h11, 16'hA5C3, 1'b0, 16'h0);
        @(negedge clk);
        rd_reg(2'd0, v);
        chk(v == 32'h0011_0511, "R4 command readback while busy", 64'(v), 64'h0011_0511);
        wait_done("R4 write");
        rd_reg(2'd2, v); chk(v == 0, "R6 status after write", 64'(v), 64'd0);

        // R3 read with PHY answer, R5 data placement
        launch(1'b1, 5'h1F, 5'h02, 16'h0, 1'b1, 16'h3C5A);
        wait_done("R4 read");
        rd_reg(2'd1, v); chk(v == 32'h3C5A_A5C3, "R5 read data placement", 64'(v), 64'h3C5A_A5C3);
        rd_reg(2'd2, v); chk(v == 0, "R6 status valid read", 64'(v), 64'd0);

        // R6 silent PHY: invalid flag, line high data
        launch(1'b1, 5'd3, 5'd4, 16'h0, 1'b0, 16'h0);
        wait_done("R4 silent read");
        rd_reg(2'd2, v); chk(v == 1, "R6 invalid flag set", 64'(v), 64'd1);
        rd_reg(2'd1, v); chk(v == 32'hFFFF_A5C3, "R5 silent read data", 64'(v), 64'hFFFF_A5C3);

        // R6 valid read clears the flag
        launch(1'b1, 5'd7, 5'd1, 16'h0, 1'b1, 16'h0001);
        wait_done("R4 second read");
        rd_reg(2'd2, v); chk(v == 0, "R6 invalid flag cleared", 64'(v), 64'd0);
        rd_reg(2'd1, v); chk(v == 32'h0001_A5C3, "R5 second read data", 64'(v), 64'h0001_A5C3);

        // R8 command while busy is ignored
        wr_reg(2'd1, 32'h0000_1234);
        launch(1'b0, 5'd1, 5'd1, 16'h1234, 1'b0, 16'h0);
        repeat (300) @(negedge clk);
        wr_reg(2'd0, cmd_word(1'b1, 5'd9, 5'd9));
        rd_reg(2'd0, v);
        chk(v == 32'h0011_0101, "R8 readback unchanged while busy", 64'(v), 64'h0011_0101);
        wait_done("R8 busy window");
        repeat (3 * HALF) @(negedge clk);
        rd_reg(2'd0, v);
        chk(v[20] == 1'b0 && !mdc, "R8 no second transaction", 64'(v), 64'h0001_0101);

        // R9 malformed commands
        wr_reg(2'd0, 32'h0013_0202);
        rd_reg(2'd0, v);
        chk(v == 32'h0001_0101, "R9 both opcode bits ignored", 64'(v), 64'h0001_0101);
        wr_reg(2'd0, 32'h0002_0303);
        rd_reg(2'd0, v);
        chk(v == 32'h0001_0101, "R9 missing go bit ignored", 64'(v), 64'h0001_0101);
        wr_reg(2'd0, 32'h0010_0404);
        repeat (3 * HALF) @(negedge clk);
        rd_reg(2'd0, v);
        chk(v == 32'h0001_0101 && !mdc && bitcnt == 0, "R9 no opcode ignored", 64'(v), 64'h0001_0101);

        // R7 clock shape and hold, R8 no leftover frames
        chk(timing_viol == 0, "R7 MDC half periods and MDIO hold", 64'(timing_viol), 64'd0);
        chk(exp_q.size() == 0, "R8 all queued frames seen", 64'(exp_q.size()), 64'd0);
        summary_and_end();
    end
endmodule